// File: doc/BRIEF.md
# Radix-2 SRT Significand Divider

This block divides two normalized fractional significands. Each operand is an N-bit magnitude in [0.5, 1), so its top bit is always set. A start pulse captures both operands. The divider then produces one signed quotient digit from {-1, 0, +1} on each clock. The partial remainder is kept as separate sum and carry vectors, so the per-step update has no carry chain. Each digit is picked from a four-bit estimate of the doubled remainder. A digit that is slightly off is corrected by the digits that follow it. After the last digit, one finishing cycle does three things: it adds the remainder vectors together, it subtracts the negative-digit vector from the positive-digit vector, and it repairs a negative remainder by adding the divisor back while lowering the quotient by one unit in the last place.

The dividend enters the recurrence at half its value. This keeps the first remainder inside the divisor bound for every legal operand pair. As a result the quotient has one integer bit and N-1 fraction bits, and it lies in (0.5, 2). In integer terms the results satisfy `quotient * divisor + remainder = dividend * 2^(N-1)`. Sign, exponent, rounding and special values are handled outside this block.

Top module: `srt2_divider`

## Requirements
- R1: While reset is held and after it is released, busy and done are 0 and quotient and remainder read 0 until the first result.
- R2: A start sampled with busy low is accepted, including a start in the cycle where done is high. Done rises in the cycle that follows the (N+1)-th rising edge after the accepting edge. Busy is high from the accepting edge until that cycle and is low while done is high.
- R3: The results satisfy quotient * divisor + remainder = dividend * 2^(N-1) exactly. The quotient is read as 1 integer bit followed by N-1 fraction bits.
- R4: Every result has 0 <= remainder < divisor, and at least one of quotient bits N-1 and N-2 is set, because the quotient is above one half.
- R5: A start sampled while busy is high has no effect. The running division completes with its own operands, and no extra result is produced.
- R6: Done is high for exactly one cycle per accepted start. Quotient and remainder do not change between results.
- R7: Equal operands give quotient = 2^(N-1), which is 1.0, and remainder = 0.
- R8: A divisor of exactly one half (only its top bit set) gives quotient = dividend and remainder = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division; used only while busy is low |
| dividend | input | N | Dividend significand, fraction in [0.5,1) |
| divisor | input | N | Divisor significand, fraction in [0.5,1) |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: quotient and remainder are new |
| quotient | output | N | Quotient, 1 integer bit and N-1 fraction bits |
| remainder | output | N | Final remainder, in the dividend's units scaled by 2^(N-1) |

## Verification
The bench builds the divider with N = 16. At that width the products dividend * 2^15 fit easily in 64-bit integers, so every result is checked exactly against integer division. A run of one iteration is short enough that several hundred back-to-back divisions fit in the budget. At this width the extreme operands are reached directly: all-ones against one half gives the largest quotient, and one half against all-ones gives the smallest. Random operands with the top bit forced to one drive the estimate through its negative and zero-digit cases, and those cases then have to be repaired by the final correction.

// File: rtl/srt2_pkg.sv
package srt2_pkg;

   // signed quotient digit, one-hot over its nonzero values
   typedef enum logic [1:0] {
      DIG_ZERO = 2'b00,
      DIG_POS  = 2'b01,
      DIG_NEG  = 2'b10
   } sdig_t;

   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_ITER = 2'b01,
      PH_FIN  = 2'b10
   } phase_t;

   // width of the leading slice of each doubled remainder vector that feeds selection
   localparam int EST_W = 4;

endpackage

// File: rtl/srt2_digit_sel.sv
module srt2_digit_sel
   import srt2_pkg::*;
(
   input  logic [EST_W-1:0] s_top,
   input  logic [EST_W-1:0] c_top,
   output logic [EST_W-1:0] est,
   output sdig_t            dig
);

   // estimate in half units: 3 integer bits and one fraction bit
   assign est = s_top + c_top;

   always_comb begin
      if (!est[EST_W-1])
         dig = DIG_POS;                     // estimate >= 0
      else if (est == {EST_W{1'b1}})
         dig = DIG_ZERO;                    // estimate == -1/2
      else
         dig = DIG_NEG;                     // estimate <= -1
   end

endmodule

// File: rtl/srt2_csa_step.sv
module srt2_csa_step
   import srt2_pkg::*;
#(
   parameter int W = 28
) (
   input  logic [W-1:0]     s_cur,
   input  logic [W-1:0]     c_cur,
   input  logic [W-1:0]     dx,
   output sdig_t            dig,
   output logic [EST_W-1:0] est,
   output logic [W-1:0]     s_nx,
   output logic [W-1:0]     c_nx
);

   logic [W-1:0] a2, b2, addend;
   logic [W-2:0] cy;
   logic         cin;

   // doubled remainder, both vectors shifted alone (arithmetic mod 2^W)
   assign a2 = {s_cur[W-2:0], 1'b0};
   assign b2 = {c_cur[W-2:0], 1'b0};

   srt2_digit_sel u_sel (
      .s_top (a2[W-1 -: EST_W]),
      .c_top (b2[W-1 -: EST_W]),
      .est   (est),
      .dig   (dig)
   );

   // +1 subtracts the divisor (invert plus carry-in), -1 adds it, 0 adds nothing
   always_comb begin
      unique case (dig)
         DIG_POS: addend = ~dx;
         DIG_NEG: addend = dx;
         default: addend = '0;
      endcase
   end
   assign cin = (dig == DIG_POS);

   for (genvar i = 0; i < W; i++) begin : g_fa
      assign s_nx[i] = a2[i] ^ b2[i] ^ addend[i];
      if (i < W - 1) begin : g_cy
         assign cy[i] = (a2[i] & b2[i]) | (a2[i] & addend[i]) | (b2[i] & addend[i]);
      end
   end

   assign c_nx = {cy, cin};

endmodule

// File: rtl/srt2_quot_acc.sv
module srt2_quot_acc
   import srt2_pkg::*;
#(
   parameter int N = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift,
   input  sdig_t        dig,
   output logic [N-1:0] qpos,
   output logic [N-1:0] qneg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qpos <= '0;
         qneg <= '0;
      end else if (clr) begin
         qpos <= '0;
         qneg <= '0;
      end else if (shift) begin
         qpos <= {qpos[N-2:0], dig == DIG_POS};
         qneg <= {qneg[N-2:0], dig == DIG_NEG};
      end
   end

   AST_DIGIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> !(qpos[0] && qneg[0]));                                  // R3

endmodule

// File: rtl/srt2_finish.sv
module srt2_finish #(
   parameter int N = 24,
   parameter int W = N + 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire,
   input  logic [W-1:0] s_in,
   input  logic [W-1:0] c_in,
   input  logic [N-1:0] qpos,
   input  logic [N-1:0] qneg,
   input  logic [N-1:0] dvs,
   output logic         done_o,
   output logic [N-1:0] quo_o,
   output logic [N-1:0] rem_o
);

   logic [W-1:0] rsum, rfix, dx;
   logic [N:0]   qraw, qfix;
   logic         neg;

   assign dx   = {3'b000, dvs, 1'b0};
   assign rsum = s_in + c_in;
   assign neg  = rsum[W-1];
   assign rfix = neg ? rsum + dx : rsum;
   assign qraw = {1'b0, qpos} - {1'b0, qneg};
   assign qfix = qraw - {{N{1'b0}}, neg};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         quo_o  <= '0;
         rem_o  <= '0;
      end else begin
         done_o <= fire;
         if (fire) begin
            quo_o <= qfix[N-1:0];
            rem_o <= rfix[N:1];
         end
      end
   end

   AST_FIX_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (rfix[W-1:N+1] == '0 && !rfix[0] && !qfix[N]));           // R4
   AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> rem_o < dvs);                                           // R4
   AST_QUO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (quo_o[N-1] || quo_o[N-2]));                            // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                               // R6
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> ($stable(quo_o) && $stable(rem_o)));                     // R6

endmodule

// File: rtl/srt2_divider.sv
module srt2_divider
   import srt2_pkg::*;
#(
   parameter int N = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [N-1:0] dividend,
   input  logic [N-1:0] divisor,
   output logic         busy,
   output logic         done,
   output logic [N-1:0] quotient,
   output logic [N-1:0] remainder
);

   localparam int W  = N + 4;          // sign, 2 integer bits, N+1 fraction bits
   localparam int CW = $clog2(N);

   if (N < 4) begin : g_bad_width
      $error("srt2_divider: N must be at least 4");
   end

   phase_t           phase;
   logic [CW-1:0]    cnt;
   logic [W-1:0]     s_q, c_q, s_nx, c_nx, dx;
   logic [N-1:0]     dvs_q, qpos, qneg;
   logic [EST_W-1:0] est;
   sdig_t            dig;
   logic             take;

   assign take = start && (phase == PH_IDLE);
   assign busy = (phase != PH_IDLE);
   assign dx   = {3'b000, dvs_q, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         s_q   <= '0;
         c_q   <= '0;
         dvs_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               s_q   <= {4'b0000, dividend};   // dividend/2 in remainder units
               c_q   <= '0;
               dvs_q <= divisor;
               cnt   <= '0;
               phase <= PH_ITER;
            end
            PH_ITER: begin
               s_q <= s_nx;
               c_q <= c_nx;
               cnt <= cnt + 1'b1;
               if (cnt == CW'(N - 1)) phase <= PH_FIN;
            end
            PH_FIN:  phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   srt2_csa_step #(.W(W)) u_step (
      .s_cur (s_q),
      .c_cur (c_q),
      .dx    (dx),
      .dig   (dig),
      .est   (est),
      .s_nx  (s_nx),
      .c_nx  (c_nx)
   );

   srt2_quot_acc #(.N(N)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (take),
      .shift (phase == PH_ITER),
      .dig   (dig),
      .qpos  (qpos),
      .qneg  (qneg)
   );

   srt2_finish #(.N(N), .W(W)) u_fin (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (phase == PH_FIN),
      .s_in   (s_q),
      .c_in   (c_q),
      .qpos   (qpos),
      .qneg   (qneg),
      .dvs    (dvs_q),
      .done_o (done),
      .quo_o  (quotient),
      .rem_o  (remainder)
   );

   AST_EST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ITER) |-> ($signed(est) >= -5 && $signed(est) <= 3));    // R3
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(dvs_q));                                   // R5
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));                                      // R2

endmodule

// File: tb/srt2_divider_test.sv
module srt2_divider_test;

   localparam int N = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [N-1:0] dividend = '0;
   logic [N-1:0] divisor = '0;
   logic         busy, done;
   logic [N-1:0] quotient, remainder;

   always #2 clk = ~clk;   // 4 ns period

   srt2_divider #(.N(N)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .dividend  (dividend),
      .divisor   (divisor),
      .busy      (busy),
      .done      (done),
      .quotient  (quotient),
      .remainder (remainder)
   );

   typedef struct {
      logic [N-1:0] q;
      logic [N-1:0] r;
      logic [N-1:0] d;
      longint       cyc;
      string        tag;
   } exp_t;

   exp_t   sb[$];
   exp_t   mon_e;
   int     total = 0;
   int     bad = 0;
   longint cyc = 0;
   logic [N-1:0] held_q = '0;
   logic [N-1:0] held_r = '0;
   bit     prev_done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // driver: waits for idle, issues one start, pushes the expected result
   task automatic run_div(input logic [N-1:0] x, input logic [N-1:0] d, input string tag);
      exp_t   e;
      longint num;
      @(negedge clk);
      while (busy) @(negedge clk);
      num   = longint'(x) << (N - 1);
      e.q   = N'(num / longint'(d));
      e.r   = N'(num % longint'(d));
      e.d   = d;
      e.cyc = cyc + N + 2;            // R2: accept edge + N iterations + finish edge
      e.tag = tag;
      sb.push_back(e);
      start    = 1'b1;
      dividend = x;
      divisor  = d;
      @(negedge clk);
      start = 1'b0;
   endtask

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (sb.size() == 0) begin
               check(1'b0, "R5", "result without accepted start", 1, 0);
            end else begin
               mon_e = sb.pop_front();
               check(quotient == mon_e.q, mon_e.tag, "quotient", quotient, mon_e.q);
               check(remainder == mon_e.r, mon_e.tag, "remainder", remainder, mon_e.r);
               check(remainder < mon_e.d, "R4", "remainder below divisor", remainder, mon_e.d);
               check(quotient[N-1] || quotient[N-2], "R4", "quotient above one half", quotient, 0);
               check(cyc == mon_e.cyc, "R2", "done cycle", cyc, mon_e.cyc);
               check(!busy, "R2", "busy low with done", busy, 0);
            end
            check(!prev_done, "R6", "done longer than one cycle", 1, 0);
            held_q = quotient;
            held_r = remainder;
         end else begin
            check(quotient == held_q, "R6", "quotient held", quotient, held_q);
            check(remainder == held_r, "R6", "remainder held", remainder, held_r);
         end
         prev_done = done;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
      check(quotient == '0 && remainder == '0, "R1", "results in reset", quotient, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);

      // R7: equal operands give exactly 1.0
      run_div(16'hC000, 16'hC000, "R7");
      run_div(16'hFFFF, 16'hFFFF, "R7");
      run_div(16'h8000, 16'h8000, "R7");
      // R8: divisor one half returns the dividend
      run_div(16'hABCD, 16'h8000, "R8");
      run_div(16'hFFFF, 16'h8000, "R8");
      // R3: extreme ratios
      run_div(16'h8000, 16'hFFFF, "R3");
      run_div(16'h8001, 16'hFFFE, "R3");
      run_div(16'hFFFE, 16'h8001, "R3");
      run_div(16'hAAAA, 16'hD555, "R3");

      // R3 / R2: random operands issued back to back
      for (int i = 0; i < 300; i++)
         run_div({1'b1, 15'($urandom)}, {1'b1, 15'($urandom)}, "R3");

      // R5: a start while busy must not disturb the running division
      run_div(16'h9123, 16'hE456, "R5");
      repeat (4) @(negedge clk);
      check(busy, "R5", "busy during division", busy, 1);
      start    = 1'b1;
      dividend = 16'hFFFF;
      divisor  = 16'h8000;
      @(negedge clk);
      start = 1'b0;
      run_div(16'hF0F0, 16'h8F0F, "R5");

      while (sb.size() != 0) @(negedge clk);
      repeat (N + 4) @(negedge clk);
      check(!busy, "R5", "idle after drain", busy, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule